// File: doc/BRIEF.md
# Banked Scratchpad Conflict Serializer

This block services one access request from a group of 16 lanes against a word-interleaved scratchpad made of 16 single-ported banks. Each lane brings a valid bit, a word address and, for a store request, a data word. Every bank can serve one word per cycle. The block therefore splits the request into conflict-free passes and runs one pass per cycle until every valid lane has been served.

Lanes whose addresses fall in different banks are served together in the same pass. Lanes that address different words in one bank are spread over successive passes. Lanes that address the same word share one bank access: a load returns that word to all of them (a broadcast), and for a store the highest-numbered lane's data is written.

When the last pass is finished, the block raises a one-cycle done pulse. At that point the per-lane read data and the number of passes the request took are valid. A request is either all loads or all stores. A new request is accepted only while the block is idle.

Top module: `sp_conflict_serializer`

## Requirements
- R1: The bank of a lane is the low 4 bits of its word address (address modulo 16). The row within that bank is the remaining upper address bits.
- R2: A request is taken when `req_valid_i` is high and `busy_o` is low. While `busy_o` is high, `req_valid_i` and all lane inputs are ignored.
- R3: A request whose valid lanes all fall in distinct banks completes in exactly one pass.
- R4: The pass count equals the largest number of distinct word addresses among valid lanes that map to any one bank. Lanes addressing different words of one bank are served in separate passes.
- R5: A load from the same word by several lanes is a broadcast. Every one of those lanes receives the word, and no extra pass is taken.
- R6: A strided pattern `base + s*lane` over all 16 lanes takes one pass for odd `s`. It takes `gcd(s,16)` passes for even `s` (for example, 2 passes for `s=2` and 16 passes for `s=16`).
- R7: When several lanes store to the same word, the data of the highest-numbered of those lanes is the value written.
- R8: `done_o` is a single-cycle pulse. It rises `max(P,1)` clock edges after the accepting edge, where P is the pass count. `pass_cnt_o` holds P while `done_o` is high. A request with no valid lanes completes with P = 0.
- R9: A lane that is not valid accesses no bank. Its `lane_rdata_o` reads 0 after the request, and it writes nothing on a store.
- R10: After reset, `busy_o` and `done_o` are low, `pass_cnt_o` and all read data are 0, and every scratchpad word holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe, taken while idle |
| req_store_i | input | 1 | 1 = store request, 0 = load request |
| lane_valid_i | input | LANES | Per-lane participation |
| lane_addr_i | input | LANES*ADDR_W | Per-lane word address |
| lane_wdata_i | input | LANES*DATA_W | Per-lane store data |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle pulse after the final pass |
| pass_cnt_o | output | CNT_W | Passes used by the last request |
| lane_rdata_o | output | LANES*DATA_W | Per-lane load result |

## Verification
The bench builds the block with its default values: 16 lanes, 16 banks, an 8-bit word address (16 rows per bank) and 32-bit data. Under these values the worst case of all 16 lanes in one bank with distinct rows, giving 16 passes, can be reached. The full even-stride family can also be reached: stride 2 gives 2 passes, stride 4 gives 4 and stride 16 gives 16. Random requests draw addresses from a narrow pool, so that broadcasts, same-word stores and mixed conflict degrees all occur together in a single request.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic {
    SP_LOAD  = 1'b0,
    SP_STORE = 1'b1
  } sp_op_e;
endpackage

// File: rtl/sp_bank.sv
module sp_bank #(
  parameter int ROW_W  = 4,
  parameter int DATA_W = 32,
  localparam int DEPTH = 1 << ROW_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DEPTH-1:0][DATA_W-1:0] mem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mem_q <= '0;
    else if (we_i) mem_q[row_i] <= wdata_i;
  end

  assign rdata_o = mem_q[row_i];
endmodule

// File: rtl/sp_pass_arbiter.sv
module sp_pass_arbiter #(
  parameter int LANES  = 16,
  parameter int BANKS  = 16,
  parameter int ADDR_W = 8,
  localparam int BANK_W = $clog2(BANKS)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [LANES-1:0]             pending_i,
  input  logic [LANES-1:0][ADDR_W-1:0] addr_i,
  output logic [LANES-1:0]             grant_o
);
  logic [ADDR_W-1:0] lead;

  // lowest pending lane in a bank sets the word; same-word lanes ride along
  always_comb begin
    grant_o = '0;
    lead    = '0;
    for (int l = 0; l < LANES; l++) begin
      lead = addr_i[l];
      for (int j = LANES - 1; j >= 0; j--) begin
        if (pending_i[j] && addr_i[j][BANK_W-1:0] == addr_i[l][BANK_W-1:0])
          lead = addr_i[j];
      end
      grant_o[l] = pending_i[l] && (lead == addr_i[l]);
    end
  end

  logic clash;
  always_comb begin
    clash = 1'b0;
    for (int a = 0; a < LANES; a++)
      for (int b = a + 1; b < LANES; b++)
        if (grant_o[a] && grant_o[b] &&
            addr_i[a][BANK_W-1:0] == addr_i[b][BANK_W-1:0] && addr_i[a] != addr_i[b])
          clash = 1'b1;
  end

  // R4: one word per bank per pass
  p_one_word_per_bank_r4: assert property (@(posedge clk_i) disable iff (!rst_ni) !clash);
  // R9: only pending lanes are served
  p_grant_in_pending_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o & ~pending_i) == '0);
  // R4: every pass makes progress
  p_progress_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_i != '0) |-> (grant_o != '0));
endmodule

// File: rtl/sp_conflict_serializer.sv
module sp_conflict_serializer
  import sp_pkg::*;
#(
  parameter int LANES  = 16,
  parameter int BANKS  = 16,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  localparam int BANK_W = $clog2(BANKS),
  localparam int ROW_W  = ADDR_W - BANK_W,
  localparam int CNT_W  = $clog2(LANES + 1)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         req_valid_i,
  input  logic                         req_store_i,
  input  logic [LANES-1:0]             lane_valid_i,
  input  logic [LANES-1:0][ADDR_W-1:0] lane_addr_i,
  input  logic [LANES-1:0][DATA_W-1:0] lane_wdata_i,
  output logic                         busy_o,
  output logic                         done_o,
  output logic [CNT_W-1:0]             pass_cnt_o,
  output logic [LANES-1:0][DATA_W-1:0] lane_rdata_o
);
  logic                         busy_q, done_q;
  sp_op_e                       op_q;
  logic [LANES-1:0]             pending_q, grant;
  logic [LANES-1:0][ADDR_W-1:0] addr_q;
  logic [LANES-1:0][DATA_W-1:0] wdata_q, rd_q;
  logic [CNT_W-1:0]             cnt_q;

  logic [BANKS-1:0]             bank_we;
  logic [BANKS-1:0][ROW_W-1:0]  bank_row;
  logic [BANKS-1:0][DATA_W-1:0] bank_wd, bank_rd;
  logic [LANES-1:0]             active;

  assign active = busy_q ? pending_q : '0;

  sp_pass_arbiter #(.LANES(LANES), .BANKS(BANKS), .ADDR_W(ADDR_W)) u_arb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pending_i(active),
    .addr_i   (addr_q),
    .grant_o  (grant)
  );

  // bank port steering; later (higher) lanes override on same-word stores
  always_comb begin
    bank_we  = '0;
    bank_row = '0;
    bank_wd  = '0;
    for (int b = 0; b < BANKS; b++) begin
      for (int l = 0; l < LANES; l++) begin
        if (grant[l] && addr_q[l][BANK_W-1:0] == BANK_W'(b)) begin
          bank_row[b] = addr_q[l][ADDR_W-1:BANK_W];
          if (op_q == SP_STORE) begin
            bank_we[b] = 1'b1;
            bank_wd[b] = wdata_q[l];
          end
        end
      end
    end
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    sp_bank #(.ROW_W(ROW_W), .DATA_W(DATA_W)) u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (bank_we[b]),
      .row_i  (bank_row[b]),
      .wdata_i(bank_wd[b]),
      .rdata_o(bank_rd[b])
    );
  end

  logic [LANES-1:0] left;
  assign left = pending_q & ~grant;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      op_q      <= SP_LOAD;
      pending_q <= '0;
      addr_q    <= '0;
      wdata_q   <= '0;
      rd_q      <= '0;
      cnt_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (req_valid_i) begin
          busy_q    <= 1'b1;
          op_q      <= sp_op_e'(req_store_i);
          pending_q <= lane_valid_i;
          addr_q    <= lane_addr_i;
          wdata_q   <= lane_wdata_i;
          rd_q      <= '0;
          cnt_q     <= '0;
        end
      end else begin
        pending_q <= left;
        if (grant != '0) cnt_q <= cnt_q + CNT_W'(1);
        for (int l = 0; l < LANES; l++)
          if (grant[l] && op_q == SP_LOAD)
            rd_q[l] <= bank_rd[addr_q[l][BANK_W-1:0]];
        if (left == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o       = busy_q;
  assign done_o       = done_q;
  assign pass_cnt_o   = cnt_q;
  assign lane_rdata_o = rd_q;

  // R8: done is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R4: never more passes than lanes
  p_cnt_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(LANES));
  // R2: no new lanes join while busy
  p_no_join_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> (pending_q & ~$past(pending_q)) == '0);
  // R8: done only at the end of a request
  p_done_after_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(busy_o));
endmodule

// File: tb/sp_conflict_serializer_bench.sv
module sp_conflict_serializer_bench;
  localparam int LANES = 16, BANKS = 16, ADDR_W = 8, DATA_W = 32;
  localparam int CNT_W = $clog2(LANES + 1);
  localparam int WORDS = 1 << ADDR_W;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic req_valid = 1'b0, req_store = 1'b0;
  logic [LANES-1:0] lane_valid = '0;
  logic [LANES-1:0][ADDR_W-1:0] lane_addr = '0;
  logic [LANES-1:0][DATA_W-1:0] lane_wdata = '0;
  logic busy, done;
  logic [CNT_W-1:0] pass_cnt;
  logic [LANES-1:0][DATA_W-1:0] lane_rdata;

  sp_conflict_serializer u_sp_conflict_serializer (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_store_i(req_store),
    .lane_valid_i(lane_valid), .lane_addr_i(lane_addr), .lane_wdata_i(lane_wdata),
    .busy_o(busy), .done_o(done), .pass_cnt_o(pass_cnt), .lane_rdata_o(lane_rdata));

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;
  logic [DATA_W-1:0] model [WORDS];
  logic [ADDR_W-1:0] t_addr [LANES];
  logic [DATA_W-1:0] t_wd [LANES];

  task automatic check(input string req, input string what, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_passes(input logic [LANES-1:0] vm);
    int per_bank [BANKS];
    int mx = 0;
    for (int b = 0; b < BANKS; b++) per_bank[b] = 0;
    for (int l = 0; l < LANES; l++) begin
      bit seen = 1'b0;
      if (!vm[l]) continue;
      for (int j = 0; j < l; j++) if (vm[j] && t_addr[j] == t_addr[l]) seen = 1'b1;
      if (!seen) per_bank[t_addr[l] % BANKS]++;
    end
    for (int b = 0; b < BANKS; b++) if (per_bank[b] > mx) mx = per_bank[b];
    return mx;
  endfunction

  // runs one request; while busy, inputs are scrambled and req_valid held high (R2)
  task automatic run(input bit st, input logic [LANES-1:0] vm, input string tag, input int want);
    int p, lat, edges;
    p = exp_passes(vm);
    if (want >= 0) check(tag, "expected pass count from rule", p, want);
    @(negedge clk);
    req_valid = 1'b1; req_store = st; lane_valid = vm;
    for (int l = 0; l < LANES; l++) begin
      lane_addr[l] = t_addr[l]; lane_wdata[l] = t_wd[l];
    end
    @(negedge clk);
    req_store = ~st; lane_valid = ~vm;
    for (int l = 0; l < LANES; l++) begin
      lane_addr[l] = ADDR_W'($urandom); lane_wdata[l] = $urandom;
    end
    edges = 0;
    while (!done && edges < 40) begin
      @(negedge clk); edges++;
    end
    req_valid = 1'b0;
    lat = (p > 1) ? p : 1;
    check({tag, " R8"}, "done latency", edges, lat);
    check({tag, " R4"}, "pass count", 32'(pass_cnt), p);
    if (!st) begin
      for (int l = 0; l < LANES; l++)
        check({tag, " R5 R9"}, $sformatf("lane %0d rdata", l), lane_rdata[l],
              vm[l] ? model[t_addr[l]] : '0);
    end else begin
      for (int l = 0; l < LANES; l++) if (vm[l]) model[t_addr[l]] = t_wd[l];
    end
    @(negedge clk);
    check({tag, " R8"}, "done dropped", done, 1'b0);
  endtask

  task automatic stride(input int base, input int s, input int want, input string tag);
    for (int l = 0; l < LANES; l++) t_addr[l] = ADDR_W'(base + s * l);
    run(1'b0, '1, tag, want);
  endtask

  initial begin
    void'($urandom(32'd7));
    for (int w = 0; w < WORDS; w++) model[w] = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10", "busy", busy, 0);
    check("R10", "done", done, 0);
    check("R10", "pass_cnt", 32'(pass_cnt), 0);
    check("R10", "rdata lane0", lane_rdata[0], 0);
    rst_n = 1'b1;
    // R10 memory reads zero, R1/R3 distinct banks
    for (int l = 0; l < LANES; l++) begin t_addr[l] = ADDR_W'(l * 17); t_wd[l] = '0; end
    run(1'b0, '1, "R10 R3 zero", 1);
    // fill memory so loads see distinct data
    for (int r = 0; r < WORDS / LANES; r++) begin
      for (int l = 0; l < LANES; l++) begin
        t_addr[l] = ADDR_W'(r * LANES + l); t_wd[l] = 32'hA500_0000 + 32'(r * LANES + l);
      end
      run(1'b1, '1, "R1 R3 fill", 1);
    end
    // R1 distinct banks, shuffled rows
    for (int l = 0; l < LANES; l++) t_addr[l] = ADDR_W'(((15 - l) << 4) | l);
    run(1'b0, '1, "R1 R3 shuffled", 1);
    // R6 strides
    stride(5, 1, 1, "R6 s1");
    stride(2, 3, 1, "R6 s3");
    stride(0, 7, 1, "R6 s7");
    stride(1, 2, 2, "R6 s2");
    stride(0, 4, 4, "R6 s4");
    stride(3, 16, 16, "R6 s16");
    // R5 full broadcast
    for (int l = 0; l < LANES; l++) t_addr[l] = 8'h2B;
    run(1'b0, '1, "R5 broadcast", 1);
    // R4 two words per bank plus broadcast partners
    for (int l = 0; l < LANES; l++) t_addr[l] = (l < 8) ? 8'h03 : 8'h13;
    run(1'b0, '1, "R4 R5 two words", 2);
    // R9 sparse mask
    for (int l = 0; l < LANES; l++) t_addr[l] = ADDR_W'(l * 16);
    run(1'b0, 16'h0101, "R9 sparse", 2);
    // R8 empty request
    run(1'b0, '0, "R8 empty", 0);
    // R7 same-word stores: highest lane wins
    for (int l = 0; l < LANES; l++) begin t_addr[l] = 8'h44; t_wd[l] = 32'hC0DE_0000 + 32'(l); end
    run(1'b1, 16'h7FF3, "R7 store", 1);
    run(1'b0, '1, "R7 readback", 1);
    check("R7", "winner word", model[8'h44], 32'hC0DE_000E);
    // R9 invalid store lane writes nothing
    for (int l = 0; l < LANES; l++) begin t_addr[l] = 8'h55; t_wd[l] = 32'hDEAD_0000 + 32'(l); end
    run(1'b1, 16'h0004, "R9 store mask", 1);
    run(1'b0, '1, "R9 readback", 1);
    check("R9", "masked store word", model[8'h55], 32'hDEAD_0002);
    // random mixes
    for (int it = 0; it < 60; it++) begin
      logic [LANES-1:0] vm;
      bit st;
      int span;
      span = (it % 3 == 0) ? 8 : 48;
      vm = LANES'($urandom);
      st = ($urandom % 3) == 0;
      for (int l = 0; l < LANES; l++) begin
        t_addr[l] = ADDR_W'($urandom % span); t_wd[l] = $urandom;
      end
      run(st, vm, "R4 random", -1);
      if (st) run(1'b0, vm, "R7 random readback", -1);
    end
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule